// File: doc/BRIEF.md
# Mode-gated full-duplex SPI slave

This block is a serial slave that a host controller reaches through four wires: a serial clock, a data line into the block, a data line out of it, and an active-low select. Every 16-bit frame carries an address into a bank of eight 12-bit configuration registers, a read-only flag and a 12-bit payload. While the host shifts that frame in, the block shifts back a 4-bit status header and the current contents of the addressed register, so every frame also reads.

Whether a write takes effect depends on the chip's operating mode, given on a 2-bit input. Ordinary configuration registers may only be written in the two run-time modes (normal, standby). A parameter marks the protected registers, by default addresses 6 and 7, which hold watchdog setup and special-mode entry; these may only be written in the two boot modes (start-up, restart). The serial pins are oversampled by the system clock, which must run at least twelve times faster than the serial clock (2 MHz serial against a 50 MHz core). The rest of the chip reads the bank through a plain combinational read port.

Top module: `spi_mode_gated_slave`

## Requirements
- R1: A frame is 16 bits, MSB first: address in bits 15:13, read-only flag in bit 12 (1 = read-only), payload in bits 11:0. It is acted on only when select rises after exactly 16 falling serial-clock edges.
- R2: MOSI is sampled on the falling serial-clock edge; MISO changes only after a rising edge, so it is stable across every falling edge.
- R3: The 16 bits sent on MISO are {mode[1:0], refused flag, bad-length flag, contents of the addressed register as held before this frame}, MSB first; the two flags describe the previous frame.
- R4: A frame with the read-only flag set changes no register and clears the refused flag.
- R5: A register whose bit in the protected mask is 0 is written only in normal (2'b10) or standby (2'b11) mode; in start-up (2'b00) or restart (2'b01) the write is ignored and the refused flag is set.
- R6: A protected register (default addresses 6 and 7) is written only in start-up (2'b00) or restart (2'b01); in normal or standby the write is ignored and the refused flag is set.
- R7: A frame of any length other than 16 clocks is discarded, sets the bad-length flag and clears the refused flag; a 16-clock frame clears the bad-length flag.
- R8: `miso_en` is high while select is low and a frame is in progress, and low once select is high.
- R9: After reset every register reads 0, both flags are 0 and `miso_en` is low.
- R10: `rd_data` shows the register at `rd_addr`, updated a few clock cycles after the select edge that commits a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 2 | Operating mode: 00 start-up, 01 restart, 10 normal, 11 standby |
| sck | input | 1 | Serial clock from the host, idle low |
| mosi | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low frame select |
| miso | output | 1 | Serial data to the host |
| miso_en | output | 1 | Drive enable for the MISO pad; low means high impedance |
| rd_addr | input | 3 | Register index for the chip-side read port |
| rd_data | output | 12 | Contents of the register at rd_addr |

## Verification
The host model flips MOSI to the wrong value at each rising edge and restores it halfway through the high phase, so a slave that sampled on the rising edge would capture inverted data. It also checks that MISO holds its value across each falling edge. Each mode is paired with both register classes, so a swapped or missing permission test shows up as a changed register or a wrong refused flag in the next header. Frames of 8 and 17 clocks must leave the bank untouched, which catches a commit keyed on reaching 16 rather than on ending at 16. Read-only frames carry nonzero payloads, so a write path that ignored the flag would corrupt the read-back.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

    typedef enum logic [1:0] {
        MD_STARTUP = 2'b00,
        MD_RESTART = 2'b01,
        MD_NORMAL  = 2'b10,
        MD_STANDBY = 2'b11
    } op_mode_e;

    // Width of the status part carried in the frame header
    localparam int STAT_BITS = 4;

    // Protected registers belong to the boot modes, the rest to the run modes
    function automatic logic wr_allowed(input op_mode_e mode, input logic prot);
        logic boot;
        boot = (mode == MD_STARTUP) || (mode == MD_RESTART);
        return prot ? boot : !boot;
    endfunction

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
    parameter int          W   = 1,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: RST, s2: RST};
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/spi_slv_frame.sv
module spi_slv_frame #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 12,
    localparam int HDR_W   = ADDR_W + 1,
    localparam int FRAME_W = HDR_W + DATA_W,
    localparam int CNT_W   = $clog2(FRAME_W + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_s,
    input  logic               mosi_s,
    input  logic               csn_s,
    input  logic [HDR_W-1:0]   hdr,
    input  logic [DATA_W-1:0]  tx_word,
    output logic [ADDR_W-1:0]  tx_addr,
    output logic               miso,
    output logic               miso_en,
    output logic               commit,
    output logic               len_ok,
    output logic [FRAME_W-1:0] rx_frame
);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_ADR  = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);

    typedef struct packed {
        logic               sck_p;
        logic               csn_p;
        logic               act;
        logic               miso;
        logic               commit;
        logic               len_ok;
        logic [CNT_W-1:0]   fcnt;
        logic [CNT_W-1:0]   rcnt;
        logic [FRAME_W-1:0] rx;
        logic [HDR_W-1:0]   hsh;
        logic [DATA_W-1:0]  tsh;
        logic [ADDR_W-1:0]  addr;
    } st_t;

    st_t  st_d, st_q;
    logic fall, rise, cs_fall, cs_rise;

    always_comb begin
        fall    = st_q.sck_p & ~sck_s;
        rise    = ~st_q.sck_p & sck_s;
        cs_fall = st_q.csn_p & ~csn_s;
        cs_rise = ~st_q.csn_p & csn_s;

        st_d        = st_q;
        st_d.sck_p  = sck_s;
        st_d.csn_p  = csn_s;
        st_d.commit = 1'b0;

        if (cs_fall) begin
            st_d.act  = 1'b1;
            st_d.fcnt = '0;
            st_d.rcnt = '0;
            st_d.rx   = '0;
            st_d.hsh  = hdr;
            st_d.tsh  = '0;
            st_d.addr = '0;
            st_d.miso = 1'b0;
        end else if (cs_rise) begin
            if (st_q.act) begin
                st_d.commit = 1'b1;
                st_d.len_ok = (st_q.fcnt == CNT_FULL);
            end
            st_d.act  = 1'b0;
            st_d.miso = 1'b0;
        end else if (st_q.act) begin
            if (fall) begin
                st_d.rx = {st_q.rx[FRAME_W-2:0], mosi_s};
                if (st_q.fcnt == CNT_ADR)
                    st_d.addr = {st_q.rx[ADDR_W-2:0], mosi_s};
                if (st_q.fcnt != CNT_MAX)
                    st_d.fcnt = st_q.fcnt + 1'b1;
            end
            if (rise) begin
                if (st_q.rcnt < CNT_HDR) begin
                    st_d.miso = st_q.hsh[HDR_W-1];
                    st_d.hsh  = {st_q.hsh[HDR_W-2:0], 1'b0};
                end else if (st_q.rcnt == CNT_HDR) begin
                    st_d.miso = tx_word[DATA_W-1];
                    st_d.tsh  = {tx_word[DATA_W-2:0], 1'b0};
                end else if (st_q.rcnt < CNT_FULL) begin
                    st_d.miso = st_q.tsh[DATA_W-1];
                    st_d.tsh  = {st_q.tsh[DATA_W-2:0], 1'b0};
                end else begin
                    st_d.miso = 1'b0;
                end
                if (st_q.rcnt != CNT_MAX)
                    st_d.rcnt = st_q.rcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.csn_p <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_addr  = st_q.addr;
    assign miso     = st_q.miso;
    assign miso_en  = st_q.act;
    assign commit   = st_q.commit;
    assign len_ok   = st_q.len_ok;
    assign rx_frame = st_q.rx;

    // R2: during a frame the output bit only moves after a rising clock edge
    a_r2_miso_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.act && !csn_s && !cs_fall) && !$stable(st_q.miso))
            |-> $past(sck_s && !st_q.sck_p));

    // R8: the pad is released after select goes high
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csn_s) |=> !miso_en);

    // R8: the pad is driven after select goes low
    a_r8_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(csn_s) |=> miso_en);

    // R1: a frame end yields a single commit pulse
    a_r1_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
endmodule

// File: rtl/spi_slv_bank.sv
module spi_slv_bank
    import spi_slv_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 12,
    parameter logic [(1<<ADDR_W)-1:0] PROT_MASK = 8'hC0,
    localparam int NREG    = 1 << ADDR_W,
    localparam int FRAME_W = ADDR_W + 1 + DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode,
    input  logic               commit,
    input  logic               len_ok,
    input  logic [FRAME_W-1:0] frame,
    input  logic [ADDR_W-1:0]  tx_addr,
    output logic [DATA_W-1:0]  tx_word,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rej,
    output logic               bad
);
    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
        logic                        rej;
        logic                        bad;
    } st_t;

    st_t st_d, st_q;

    logic [ADDR_W-1:0] f_addr;
    logic              f_ro;
    logic [DATA_W-1:0] f_data;
    logic              f_ok;
    logic [NREG-1:0]   we;

    assign f_addr = frame[FRAME_W-1 -: ADDR_W];
    assign f_ro   = frame[DATA_W];
    assign f_data = frame[DATA_W-1:0];
    assign f_ok   = wr_allowed(op_mode_e'(mode), PROT_MASK[f_addr]);

    for (genvar g = 0; g < NREG; g++) begin : g_we
        assign we[g] = commit && len_ok && !f_ro && (f_addr == ADDR_W'(g))
                       && wr_allowed(op_mode_e'(mode), PROT_MASK[g]);
    end

    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d.bad = !len_ok;
            st_d.rej = len_ok && !f_ro && !f_ok;
        end
        for (int i = 0; i < NREG; i++) begin
            if (we[i]) st_d.regs[i] = f_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_word = st_q.regs[tx_addr];
    assign rd_data = st_q.regs[rd_addr];
    assign rej     = st_q.rej;
    assign bad     = st_q.bad;

    // R7: a frame of the wrong length leaves the bank alone and raises the flag
    a_r7_bad_length_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !len_ok) |=> ($stable(st_q.regs) && st_q.bad && !st_q.rej));

    // R4: a read-only frame leaves the bank alone
    a_r4_read_only_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && len_ok && f_ro) |=> ($stable(st_q.regs) && !st_q.rej));

    // R5, R6: a write the mode does not permit is refused
    a_r5_r6_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && len_ok && !f_ro && !f_ok) |=> ($stable(st_q.regs) && st_q.rej));

    // R10: the bank only changes at a commit
    a_r10_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(st_q.regs));
endmodule

// File: rtl/spi_mode_gated_slave.sv
module spi_mode_gated_slave
    import spi_slv_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 12,
    parameter logic [(1<<ADDR_W)-1:0] PROT_MASK = 8'hC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_mode,
    input  logic              sck,
    input  logic              mosi,
    input  logic              cs_n,
    output logic              miso,
    output logic              miso_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    // The header must hold the status bits, so ADDR_W + 1 >= STAT_BITS
    localparam int HDR_W   = ADDR_W + 1;
    localparam int FRAME_W = HDR_W + DATA_W;

    logic [2:0]         pins_s;
    logic               sck_s, mosi_s, csn_s;
    logic [HDR_W-1:0]   hdr;
    logic [DATA_W-1:0]  tx_word;
    logic [ADDR_W-1:0]  tx_addr;
    logic               commit, len_ok, rej, bad;
    logic [FRAME_W-1:0] rx_frame;

    spi_slv_sync #(.W(3), .RST(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, sck, mosi}),
        .dout (pins_s)
    );

    assign csn_s  = pins_s[2];
    assign sck_s  = pins_s[1];
    assign mosi_s = pins_s[0];

    always_comb begin
        hdr = '0;
        hdr[STAT_BITS-1:0] = {op_mode, rej, bad};
    end

    spi_slv_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (sck_s),
        .mosi_s  (mosi_s),
        .csn_s   (csn_s),
        .hdr     (hdr),
        .tx_word (tx_word),
        .tx_addr (tx_addr),
        .miso    (miso),
        .miso_en (miso_en),
        .commit  (commit),
        .len_ok  (len_ok),
        .rx_frame(rx_frame)
    );

    spi_slv_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_MASK(PROT_MASK)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (op_mode),
        .commit (commit),
        .len_ok (len_ok),
        .frame  (rx_frame),
        .tx_addr(tx_addr),
        .tx_word(tx_word),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .rej    (rej),
        .bad    (bad)
    );
endmodule

// File: tb/spi_mode_gated_slave_test.sv
module spi_mode_gated_slave_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_mode = 2'b10;
    logic        sck = 1'b0;
    logic        mosi = 1'b0;
    logic        cs_n = 1'b1;
    logic [2:0]  rd_addr = '0;
    wire         miso, miso_en;
    wire  [11:0] rd_data;

    localparam logic [7:0] PROT = 8'hC0;

    int checks = 0;
    int errors = 0;

    logic [11:0] mreg [8];
    logic        mrej = 1'b0;
    logic        mbad = 1'b0;

    always #10 clk = ~clk;

    spi_mode_gated_slave uut (
        .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .sck(sck), .mosi(mosi),
        .cs_n(cs_n), .miso(miso), .miso_en(miso_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Host side: MOSI is wrong right after each rising edge and correct before the falling edge
    task automatic xfer(input int n, input logic [15:0] w, output logic [15:0] r,
                        output bit en_ok, output bit hold_ok);
        r = '0; en_ok = 1'b1; hold_ok = 1'b1;
        cs_n = 1'b0;
        #200;
        for (int i = 0; i < n; i++) begin
            logic b, m;
            b = (i < 16) ? w[15-i] : 1'b0;
            sck = 1'b1; mosi = ~b;
            #125; mosi = b;
            #125;
            if (!miso_en) en_ok = 1'b0;
            m = miso;
            if (i < 16) r = {r[14:0], m};
            sck = 1'b0;
            #200;
            if (miso !== m) hold_ok = 1'b0;
            #50;
        end
        #200;
        cs_n = 1'b1;
        #400;
    endtask

    task automatic frame(input string tag, input logic [1:0] md, input int n,
                         input logic [2:0] a, input bit ro, input logic [11:0] dat);
        logic [15:0] r, exp;
        bit en_ok, hold_ok, allow;
        op_mode = md;
        #100;
        exp = {md, mrej, mbad, mreg[a]};
        xfer(n, {a, ro, dat}, r, en_ok, hold_ok);
        if (n == 16) chk(r == exp, {"R3 returned word: ", tag}, 32'(r), 32'(exp));
        chk(en_ok, "R8 miso_en high within frame", 32'(en_ok), 32'd1);
        chk(!miso_en, "R8 miso_en low after select release", 32'(miso_en), 32'd0);
        chk(hold_ok, "R2 miso stable across falling edge", 32'(hold_ok), 32'd1);
        allow = PROT[a] ? !md[1] : md[1];
        if (n != 16) begin
            mbad = 1'b1; mrej = 1'b0;
        end else begin
            mbad = 1'b0;
            mrej = !ro && !allow;
            if (!ro && allow) mreg[a] = dat;
        end
        rd_addr = a;
        #20;
        chk(rd_data == mreg[a], tag, 32'(rd_data), 32'(mreg[a]));
    endtask

    task automatic t_reset;
        chk(miso_en == 1'b0, "R9 miso_en low after reset", 32'(miso_en), 32'd0);
        for (int i = 0; i < 8; i++) begin
            rd_addr = 3'(i);
            #20;
            chk(rd_data == 12'h000, "R9 register zero after reset", 32'(rd_data), 32'd0);
        end
    endtask

    task automatic t_normal_write;
        frame("R1 R10 write reg1 in normal", 2'b10, 16, 3'd1, 1'b0, 12'hABC);
        frame("R1 write reg4 in normal", 2'b10, 16, 3'd4, 1'b0, 12'h5A3);
        frame("R3 read back reg1", 2'b10, 16, 3'd1, 1'b1, 12'h000);
    endtask

    task automatic t_read_only;
        frame("R4 read-only frame leaves reg1", 2'b11, 16, 3'd1, 1'b1, 12'h123);
        frame("R4 read-only frame leaves reg6 in start-up", 2'b00, 16, 3'd6, 1'b1, 12'h777);
        frame("R4 reg1 still intact", 2'b10, 16, 3'd1, 1'b1, 12'hFFF);
    endtask

    task automatic t_mode_gates;
        frame("R5 general reg refused in start-up", 2'b00, 16, 3'd2, 1'b0, 12'h5A5);
        frame("R5 general reg refused in restart", 2'b01, 16, 3'd3, 1'b0, 12'h0AA);
        frame("R5 general reg written in standby", 2'b11, 16, 3'd3, 1'b0, 12'h3C3);
        frame("R6 protected reg written in start-up", 2'b00, 16, 3'd6, 1'b0, 12'h555);
        frame("R6 protected reg refused in normal", 2'b10, 16, 3'd7, 1'b0, 12'hFFF);
        frame("R6 protected reg refused in standby", 2'b11, 16, 3'd6, 1'b0, 12'h999);
        frame("R6 protected reg written in restart", 2'b01, 16, 3'd7, 1'b0, 12'h0F0);
        frame("R3 status after good write", 2'b10, 16, 3'd7, 1'b1, 12'h000);
    endtask

    task automatic t_bad_length;
        frame("R7 short frame discarded", 2'b10, 8, 3'd1, 1'b0, 12'h111);
        frame("R7 long frame discarded", 2'b10, 17, 3'd1, 1'b0, 12'h222);
        frame("R7 good frame after long one", 2'b10, 16, 3'd5, 1'b0, 12'h444);
        frame("R7 flag cleared", 2'b10, 16, 3'd5, 1'b1, 12'h000);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) mreg[i] = '0;
        #100;
        rst_n = 1'b1;
        #100;
        t_reset();
        t_normal_write();
        t_read_only();
        t_mode_gates();
        t_bad_length();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule